// File: doc/BRIEF.md
# Row Readback Packetizer

This block sits behind the JTAG master during a readback of a configuration memory revision. The master shifts out one 256-bit row at a time. Each row is offered to this block with a valid strobe, and the block turns it into one fixed-length packet of sixteen 16-bit words on a word-wide output stream. Every word carries start-of-packet and end-of-packet flags and the logical pipe identifier 0x3.

A start pulse arms the block. While it is armed, rows are accepted one at a time. The next row is held off through a ready signal until every word of the current packet has been taken downstream. This ready signal is the back-pressure that stalls the shifter. The block counts packets. After the configured number of rows has gone out (32768 by default, about one megabyte), it raises a one-cycle done pulse and disarms. Apart from a reset, nothing stops a readback once it has started.

Top module: `row_pkt_serializer`

## Requirements
- R1: After reset, out_valid, row_ready, busy and done are all low.
- R2: Before start is pulsed, row_ready stays low and rows offered on row_valid are neither accepted nor emitted. A start pulse raises busy and row_ready.
- R3: Each accepted row produces exactly WORDS_PER_ROW words, most significant word first. The first word is row_data[255:240] and the last is row_data[15:0].
- R4: out_sop is 1 on the first word of each packet and 0 on the others. out_eop is 1 on the last word and 0 on the others. out_pipe equals 0x3 on every valid word.
- R5: While any word of the current row is still unsent, row_ready is low, and a row_valid strobe in that time has no effect on the output stream.
- R6: When out_valid is high and out_ready is low, the next cycle shows the same out_valid and out_data.
- R7: Packets leave in the order their rows arrived, so the first row is emitted first and rows follow in ascending address order.
- R8: One cycle after the last word of packet number ROWS-1 is accepted downstream, done is high for exactly one cycle, busy is low, and row_ready is low.
- R9: A start pulse while busy is ignored. The row count continues, and done still follows the ROWS-th packet counted from the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a readback |
| row_valid | input | 1 | Row offered by the shifter |
| row_data | input | ROW_BITS | Row contents |
| row_ready | output | 1 | Block can take a row (back-pressure to shifter) |
| out_valid | output | 1 | Word available |
| out_data | output | WORD_BITS | Word payload |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_pipe | output | PIPE_W | Logical pipe id (0x3) |
| out_ready | input | 1 | Downstream accepts the word |
| busy | output | 1 | Readback in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong word index shows at once on the port as a misplaced sop or eop flag, or as a word taken from the wrong slice, in the same packet. A wrong row count shows only at the end of the run, as a done pulse that comes early, late or never, so the bench runs the complete readback in a small configuration and compares the done cycle exactly. A shift register that moves during a stall changes out_data on the very next cycle, and a row accepted while the previous one is still being sent corrupts the words that come right after it.

// File: rtl/row_pkt_serializer.sv
module row_pkt_serializer #(
  parameter int ROW_BITS  = 256,
  parameter int WORD_BITS = 16,
  parameter int ROWS      = 32768,
  parameter int PIPE_W    = 4,
  parameter int PIPE_ID   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 row_valid,
  input  logic [ROW_BITS-1:0]  row_data,
  output logic                 row_ready,
  output logic                 out_valid,
  output logic [WORD_BITS-1:0] out_data,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [PIPE_W-1:0]    out_pipe,
  input  logic                 out_ready,
  output logic                 busy,
  output logic                 done
);
  localparam int WPR = ROW_BITS / WORD_BITS;
  localparam int WIW = $clog2(WPR);
  localparam int RCW = $clog2(ROWS);

  logic                active, loaded, done_q;
  logic [ROW_BITS-1:0] shreg;
  logic [WIW-1:0]      widx;
  logic [RCW-1:0]      rcnt;

  wire take_row  = row_valid & row_ready;
  wire take_word = out_valid & out_ready;
  wire last_word = widx == WIW'(WPR - 1);
  wire last_row  = rcnt == RCW'(ROWS - 1);

  assign row_ready = active & ~loaded;
  assign out_valid = loaded;
  assign out_data  = shreg[ROW_BITS-1 -: WORD_BITS];
  assign out_sop   = loaded & (widx == '0);
  assign out_eop   = loaded & last_word;
  assign out_pipe  = PIPE_W'(PIPE_ID);
  assign busy      = active;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      loaded <= 1'b0;
      done_q <= 1'b0;
      shreg  <= '0;
      widx   <= '0;
      rcnt   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        rcnt   <= '0;
      end
      if (take_row) begin
        shreg  <= row_data;
        loaded <= 1'b1;
        widx   <= '0;
      end else if (take_word) begin
        shreg <= shreg << WORD_BITS;
        widx  <= widx + 1'b1;
        if (last_word) begin
          loaded <= 1'b0;
          rcnt   <= rcnt + 1'b1;
          if (last_row) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assert_row_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_ready |-> !out_valid);

  assert_row_starts_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_row |=> out_valid && out_sop);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_eop_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_word && out_eop |=> !out_valid);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !row_ready);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_row_pkt_serializer.sv
module sim_row_pkt_serializer;
  localparam int RB = 256, WB = 16, NR = 4, WPR = RB / WB;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, row_valid = 1'b0, out_ready = 1'b0;
  logic [RB-1:0] row_data = '0;
  logic row_ready, out_valid, out_sop, out_eop, busy, done;
  logic [WB-1:0] out_data;
  logic [3:0] out_pipe;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  row_pkt_serializer #(.ROW_BITS(RB), .WORD_BITS(WB), .ROWS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .row_valid(row_valid), .row_data(row_data),
    .row_ready(row_ready), .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_pipe(out_pipe), .out_ready(out_ready), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WB-1:0] wexp(input int r, input int w);
    return {8'(r) ^ 8'h5A, 8'(w) ^ 8'hC3};
  endfunction

  function automatic logic [RB-1:0] mkrow(input int r);
    logic [RB-1:0] v;
    for (int w = 0; w < WPR; w++) v[RB-1-WB*w -: WB] = wexp(r, w);
    return v;
  endfunction

  task automatic run(input int pat, input bit junk, input bit restart);
    int cyc = 0, sent = 0, got = 0, last_at = -10;
    bit prev_stall = 0;
    logic [WB-1:0] prev_data = '0;
    @(negedge clk);
    row_valid = 1'b1; row_data = {RB/4{4'hE}};
    @(negedge clk);
    chk(!row_ready && !out_valid && !busy, "R2 idle", {row_ready, out_valid, busy}, 0);
    row_valid = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && row_ready, "R2 armed", {busy, row_ready}, 3);
    forever begin
      cyc++;
      if (cyc > 5000) begin
        chk(0, "watchdog", cyc, 5000);
        break;
      end
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R6 stall hold", out_data, prev_data);
      out_ready = (pat == 0) ? 1'b1 : (cyc % 3 != 0);
      start = restart && (cyc == 12);
      if (out_valid) begin
        int r = got / WPR, w = got % WPR;
        chk(out_data == wexp(r, w), "R3 R7 word", out_data, wexp(r, w));
        chk(out_sop == (w == 0) && out_eop == (w == WPR - 1), "R4 flags",
            {out_sop, out_eop}, {w == 0, w == WPR - 1});
        chk(out_pipe == 4'h3, "R4 pipe", out_pipe, 3);
        if (out_ready) begin
          got++;
          if (got == NR * WPR) last_at = cyc;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (cyc == last_at + 1)
        chk(done && !busy && !row_ready, "R8 done", {done, busy, row_ready}, 4);
      else if (cyc == last_at + 2) begin
        chk(!done, "R8 pulse width", done, 0);
        chk(got == NR * WPR, "R9 count", got, NR * WPR);
        out_ready = 1'b0; row_valid = 1'b0; start = 1'b0;
        break;
      end else if (last_at < 0)
        chk(!done, "R8 early done", done, 0);
      if (row_ready) begin
        chk(!out_valid, "R5 gate", out_valid, 0);
        if (sent < NR) begin
          row_valid = 1'b1; row_data = mkrow(sent); sent++;
        end else row_valid = 1'b0;
      end else begin
        row_valid = junk; row_data = {RB/8{8'hBD}};
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !row_ready && !busy && !done, "R1 reset",
        {out_valid, row_ready, busy, done}, 0);
    rst_n = 1'b1;
    run(0, 1'b0, 1'b0);
    run(1, 1'b1, 1'b0);
    run(1, 1'b1, 1'b1);
    run(0, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule